// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a slave on a two-wire serial management bus (one clock line and one open-drain data line). It gives a host access to a small register bank held outside the block. Access goes through an internal pointer. The block samples both bus lines with its own system clock and detects START, repeated START and STOP. It matches a 7-bit slave address that is set by a parameter, and it drives the data line low through an output-enable.

A write transaction always places its first data byte into the pointer. An optional second byte is written to the register the pointer selects. A read transaction returns one byte from the register the pointer selects, so a read can follow an earlier pointer write with no new pointer setup. A pointer write followed by a repeated START and a read gives the usual "read byte" access. The pointer is presented on the register-bank address port at all times, and read data is taken from the bank's data port.

Top module: `smb_ptr_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal SLV_ADDR. On any other address it never drives SDA and ignores the bus until the next START.
- R2: In a write (bit 0 of the address byte is 0), the first byte after the address is acknowledged and loaded into the pointer, which appears on reg_addr_o.
- R3: A second byte in a write is acknowledged and written to the register at the pointer. This is a one-cycle reg_we_o pulse carrying reg_wdata_o, and exactly one pulse occurs per transaction.
- R4: Any third or later byte in a write is not acknowledged and causes no register write.
- R5: In a read (bit 0 of the address byte is 1), the slave returns the register at the pointer, most significant bit first, with no pointer write in the same transaction.
- R6: The pointer is 0 after reset and keeps its value across transactions until a write loads it again.
- R7: A repeated START ends the current transaction and begins a new one. A pointer write followed by a repeated START and a read returns the newly pointed register.
- R8: A START or STOP that arrives while a byte is partly shifted in abandons that byte. The pointer is unchanged and no register is written.
- R9: The SDA output-enable changes only while SCL is low.
- R10: After the single read byte, the slave releases SDA for the master's acknowledge bit and drives nothing more until the next START.
- R11: During and just after reset, sda_oe_o and reg_we_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 8 | Register-bank address (the pointer) |
| reg_wdata_o | output | 8 | Register-bank write data |
| reg_we_o | output | 1 | One-cycle register-bank write strobe |
| reg_rdata_i | input | 8 | Register-bank read data for reg_addr_o |

## Verification
The clash of interest is a bus condition that lands while the byte sequencer is part-way through a byte. In that cycle, abort detection and bit shifting both want to update the sequencer. The bench provokes it by issuing a STOP after four bits of a pointer byte, and a repeated START after three bits of a data byte. It then judges the outcome from the pointer, the running count of write strobes, and the data a follow-up read returns. A per-clock model of the bus lines also checks that the output-enable never moves while SCL is high.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_TX,
    ST_ACK,
    ST_MACK,
    ST_DROP
  } smb_st_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic sync_o,
  output logic prev_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= line_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= RST_VAL;
    else         prev_o <= sr_q[STAGES-1];
  end

  assign sync_o = sr_q[STAGES-1];
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic scl_s_i,
  input  logic scl_p_i,
  input  logic sda_s_i,
  input  logic sda_p_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_hold;

  assign scl_hold   = scl_s_i & scl_p_i;
  assign scl_rise_o = scl_s_i & ~scl_p_i;
  assign scl_fall_o = ~scl_s_i & scl_p_i;
  // SDA edges while SCL stays high are bus conditions
  assign start_o    = scl_hold & sda_p_i & ~sda_s_i;
  assign stop_o     = scl_hold & ~sda_p_i & sda_s_i;
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR    = 7'h2E,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  output logic [BYTE_W-1:0]   reg_addr_o,
  output logic [BYTE_W-1:0]   reg_wdata_o,
  output logic                reg_we_o,
  input  logic [BYTE_W-1:0]   reg_rdata_i
);
  localparam int unsigned CNT_W   = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(scl_i), .sync_o(scl_s), .prev_o(scl_p)
  );

  smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(sda_i), .sync_o(sda_s), .prev_o(sda_p)
  );

  smb_cond_det u_cond (
    .scl_s_i   (scl_s),
    .scl_p_i   (scl_p),
    .sda_s_i   (sda_s),
    .sda_p_i   (sda_p),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  smb_st_e           st_q, nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic [BYTE_W-1:0] rx_q, tx_q, ptr_q, wdata_q;
  logic              oe_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop_det) begin
        st_q   <= ST_IDLE;
        oe_q   <= 1'b0;
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start_det) begin
        st_q   <= ST_ADDR;
        oe_q   <= 1'b0;
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_PTR, ST_DATA: begin
            if (scl_rise) begin
              rx_q   <= {rx_q[BYTE_W-2:0], sda_s};
              cnt_q  <= cnt_q + 1'b1;
              full_q <= (cnt_q == CNT_LAST);
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              cnt_q  <= '0;
              if (st_q == ST_ADDR) begin
                if (rx_q[BYTE_W-1:1] == SLV_ADDR) begin
                  oe_q  <= 1'b1;
                  st_q  <= ST_ACK;
                  nxt_q <= rx_q[0] ? ST_TX : ST_PTR;
                end else begin
                  st_q <= ST_DROP;
                end
              end else if (st_q == ST_PTR) begin
                ptr_q <= rx_q;
                oe_q  <= 1'b1;
                st_q  <= ST_ACK;
                nxt_q <= ST_DATA;
              end else begin
                wdata_q <= rx_q;
                we_q    <= 1'b1;
                oe_q    <= 1'b1;
                st_q    <= ST_ACK;
                nxt_q   <= ST_DROP;   // later bytes go unacknowledged
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              st_q  <= nxt_q;
              cnt_q <= '0;
              if (nxt_q == ST_TX) begin
                tx_q <= reg_rdata_i;
                oe_q <= ~reg_rdata_i[BYTE_W-1];
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q  <= cnt_q + 1'b1;
              full_q <= (cnt_q == CNT_LAST);
            end else if (scl_fall) begin
              if (full_q) begin
                full_q <= 1'b0;
                oe_q   <= 1'b0;
                st_q   <= ST_MACK;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_fall) st_q <= ST_DROP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;

  // R9: enable is frozen while SCL is held high outside bus conditions
  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && scl_p && !start_det && !stop_det) |=> $stable(sda_oe_o));

  // R3: strobe is one cycle and coincides with the acknowledge drive
  assert_we_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  assert_we_with_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (sda_oe_o && st_q == ST_ACK));

  // R6: pointer moves only when a pointer byte completes
  assert_ptr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr_q) |-> ($past(st_q) == ST_PTR));

  // R1 / R10: ignored phases never pull SDA
  assert_drop_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DROP) |-> !sda_oe_o);

  // R8: a STOP releases the line and parks the sequencer
  assert_stop_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!sda_oe_o && st_q == ST_IDLE));

  // R11
  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R11: assert (!sda_oe_o && !reg_we_o);
  end
endmodule

// File: tb/smb_ptr_slave_tb.sv
module smb_ptr_slave_tb_top;
  localparam logic [6:0] ADDR = 7'h2E;
  localparam int Q = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic reg_we;
  logic bus_sda;

  int n_vec = 0;
  int n_bad = 0;
  int we_cnt = 0;
  int cyc = 0;
  logic [7:0] bank [256];
  logic [7:0] exp_bank [256];
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  always #2 clk_i = ~clk_i;

  assign bus_sda   = m_sda & ~sda_oe;
  assign reg_rdata = bank[reg_addr];

  smb_ptr_slave #(.SLV_ADDR(ADDR), .SYNC_STAGES(2)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (m_scl),
    .sda_i      (bus_sda),
    .sda_oe_o   (sda_oe),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_we_o   (reg_we),
    .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk_i) begin
    if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // per-clock model of the line rule (R9)
  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && prev_scl && m_scl) begin
      n_vec++;
      if (sda_oe !== prev_oe) begin
        n_bad++;
        $display("FAIL R9: oe moved with SCL high act=%0b exp=%0b", sda_oe, prev_oe);
      end
    end
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = bus_sda; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic m_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      rbit(s);
      d[i] = s;
    end
    wbit(~m_ack);
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    check({req, " read addr ack"}, ack, 1);
    recv_byte(d, 1'b0);
    check({req, " read data"}, d, exp);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int we0;
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'(i) ^ 8'hA5;
      exp_bank[i] = 8'(i) ^ 8'hA5;
    end
    repeat (5) @(negedge clk_i);
    check("R11 oe", sda_oe, 0);
    check("R11 we", reg_we, 0);
    check("R6 ptr reset", reg_addr, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R5 / R6: read at reset pointer
    do_read("R5", exp_bank[0]);

    // R1: foreign address
    bus_start();
    send_byte({7'h11, 1'b0}, ack);
    check("R1 foreign addr nack", ack, 0);
    send_byte(8'h40, ack);
    check("R1 ignored byte nack", ack, 0);
    bus_stop();
    check("R1 ptr untouched", reg_addr, 0);

    // R2: pointer-only write
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    check("R1 addr ack", ack, 1);
    send_byte(8'h10, ack);
    check("R2 ptr ack", ack, 1);
    bus_stop();
    check("R2 ptr value", reg_addr, 8'h10);
    do_read("R5", exp_bank[8'h10]);
    do_read("R6", exp_bank[8'h10]);

    // R3: write byte
    we0 = we_cnt;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h22, ack);
    send_byte(8'h5C, ack);
    check("R3 data ack", ack, 1);
    bus_stop();
    exp_bank[8'h22] = 8'h5C;
    check("R3 one strobe", we_cnt - we0, 1);
    check("R3 bank", bank[8'h22], 8'h5C);

    // R4: over-length write
    we0 = we_cnt;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h30, ack);
    send_byte(8'h77, ack);
    send_byte(8'h99, ack);
    check("R4 third byte nack", ack, 0);
    bus_stop();
    exp_bank[8'h30] = 8'h77;
    check("R4 one strobe", we_cnt - we0, 1);
    check("R4 bank", bank[8'h30], exp_bank[8'h30]);

    // R7: pointer write, repeated START, read
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h22, ack);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    check("R7 read addr ack", ack, 1);
    recv_byte(d, 1'b1);
    check("R7 data", d, exp_bank[8'h22]);
    // R10: master acked, slave must stay off the line
    for (int i = 0; i < 8; i++) begin
      rbit(ack);
      check("R10 released", ack, 1);
    end
    bus_stop();

    // R8: STOP inside pointer byte
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_stop();
    check("R8 ptr after stop", reg_addr, 8'h22);

    // R8: repeated START inside data byte
    we0 = we_cnt;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h44, ack);
    for (int i = 0; i < 3; i++) wbit(1'b0);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    recv_byte(d, 1'b0);
    bus_stop();
    check("R8 no strobe", we_cnt - we0, 0);
    check("R8 read after abort", d, exp_bank[8'h44]);

    // R6: reset clears pointer
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R6 ptr cleared", reg_addr, 0);
    check("R11 oe in reset", sda_oe, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    do_read("R6", exp_bank[0]);

    finish_run();
  end
endmodule